// File: doc/BRIEF.md
# Five-Stage Half-Band Decimator for a One-Bit Stream

This block turns a one-bit delta-sigma bit stream into signed 24-bit samples at one thirty-second of the bit rate. A 16 MHz stream therefore becomes 500 kS/s. Each input bit is first mapped to a signed level of +1 or -1. The levels then pass through five stages in series. Every stage is a symmetric half-band low-pass FIR that computes one result for every second input it accepts. Each stage therefore runs at half the rate of the stage before it.

All even-offset taps of a half-band filter, except the centre tap, are zero. The stages compute no product for those taps. The centre tap is one half and is applied as a shift. Each mirrored pair of taps is added before its single multiply. The stages nearest the input use the shortest filters. Each stage widens its data so that no sum can wrap. The last stage's result is rounded to 24 bits.

Bits arrive with a valid strobe, and idle cycles between bits are allowed. The top-level output is a one-cycle valid strobe together with a data word. The data word holds its value between strobes.

Top module: `hb_decim_chain`

## Requirements
- R1: A bit value of 1 enters the first stage as the signed level +1, and a bit value of 0 enters as -1.
- R2: Each stage produces a result on every second valid input after reset. The chain as a whole therefore produces exactly one output per 32 valid input bits.
- R3: `out_valid` is high for a single clock per result. With valid input on every clock, it rises after the fifth rising edge, counting the edge that captures the 32nd bit.
- R4: The DC gain is exactly one. A steady run of ones settles to +131072, and a steady run of zeros settles to -131072.
- R5: A steady alternating 1,0 pattern settles to exactly 0.
- R6: Coefficients are Q8 integers, so 256 means 1.0. They are:
  - first stage: 64, 128, 64
  - second and third stages: -16, 0, 80, 128, 80, 0, -16
  - fourth and fifth stages: 6, 0, -26, 0, 84, 128, 84, 0, -26, 0, 6

  Each result is the full-precision sum of the most recent taps, and samples that have not yet arrived count as zero.
- R7: Clocks with the input valid low have no effect on state or on the output values.
- R8: The full-precision result v of the fifth stage is output as floor((v + 2^22) / 2^23). This is rounding half upward to 24 bits.
- R9: A synchronous reset clears every delay line, every decimation phase and the output, so that `out_valid` is 0 and `out_data` is 0.
- R10: No intermediate sum wraps. The rounded value always fits in 24 signed bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Qualifies `bit_in` on this clock |
| bit_in | input | 1 | Delta-sigma modulator bit |
| out_valid | output | 1 | One-clock strobe marking a new output sample |
| out_data | output | 24 | Rounded signed output sample, held between strobes |

## Verification
The bench drives several input patterns.
- Steady ones and steady zeros show that the bit mapping is correct and that the DC gain is exactly one in both directions.
- An alternating pattern shows that the half-band response places a true null at half the input rate.
- A pseudo-random stream, sent with random idle gaps, exercises every coefficient and the rounding step.
- A reset in the middle of a stream, after an odd number of bits, shows whether stale delay-line contents or a stale phase leak into the samples that follow.

The reference model compares every clock, so a wrong decimation phase or wrong latency shows up as a strobe mismatch, and a wrong tap shows up as a data mismatch.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int NSTG  = 5;  // number of decimate-by-two stages
  localparam int CF    = 8;  // coefficient fraction bits (Q8)
  localparam int IN0_W = 2;  // width of the mapped +1/-1 level

  // number of non-zero off-centre coefficient pairs in a stage
  function automatic int pairs(input int s);
    case (s)
      0:       return 1;
      1, 2:    return 2;
      default: return 3;
    endcase
  endfunction

  // coefficient of pair i (pair 0 sits next to the centre tap)
  function automatic int coef(input int s, input int i);
    case (pairs(s))
      1: return 64;
      2: return (i == 0) ? 80 : -16;
      default: begin
        case (i)
          0:       return 84;
          1:       return -26;
          default: return 6;
        endcase
      end
    endcase
  endfunction

  // data width into stage s; each stage grows by CF+1 bits
  function automatic int stage_in_w(input int s);
    return IN0_W + s * (CF + 1);
  endfunction
endpackage

// File: rtl/hb_stage.sv
module hb_stage #(
  parameter int STAGE = 0,
  parameter int IW    = 2,
  parameter int OW    = IW + hb_pkg::CF + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam int P  = hb_pkg::pairs(STAGE);
  localparam int L  = 4 * P - 1;   // filter length
  localparam int C  = 2 * P - 1;   // centre tap index
  localparam int CF = hb_pkg::CF;

  logic signed [IW-1:0] dl  [1:L-1];
  logic signed [IW-1:0] win [0:L-1];
  logic signed [OW-1:0] acc;
  logic                 ph;
  logic                 fire;   // this accepted sample completes a pair

  // one multiply per mirrored pair, operands pre-added
  function automatic logic signed [OW-1:0] pair_term(
    input logic signed [IW-1:0] a, input logic signed [IW-1:0] b, input int c);
    logic signed [OW-1:0] sum;
    sum = OW'(a) + OW'(b);
    return OW'(c) * sum;
  endfunction

  always_comb begin
    win[0] = in_data;
    for (int k = 1; k < L; k++) win[k] = dl[k];
  end

  // centre tap 0.5 as a shift; even-offset zero taps never touched
  always_comb begin
    acc = OW'(win[C]) <<< (CF - 1);
    for (int i = 0; i < P; i++)
      acc = acc + pair_term(win[C-1-2*i], win[C+1+2*i], hb_pkg::coef(STAGE, i));
  end

  assign fire = in_valid && ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 1; k < L; k++) dl[k] <= '0;
      ph        <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fire;
      if (in_valid) begin
        dl[1] <= in_data;
        for (int k = 2; k < L; k++) dl[k] <= dl[k-1];
        ph <= ~ph;
      end
      if (fire) out_data <= acc;
    end
  end

  // R2: first sample of a pair gives no result, second gives one
  a_r2_first_silent: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ph) |=> !out_valid);
  a_r2_second_fires: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ph) |=> out_valid);
  // R3: strobe lasts one clock
  a_r3_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R7: without a completing sample the result is held
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && ph) |=> $stable(out_data));
  // R9: nothing emerges on the first clock after reset
  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);
endmodule

// File: rtl/hb_decim_chain.sv
module hb_decim_chain #(
  parameter int OUT_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bit_valid,
  input  logic                    bit_in,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int NSTG = hb_pkg::NSTG;
  localparam int FW   = hb_pkg::stage_in_w(NSTG - 1) + hb_pkg::CF + 1;
  localparam int SH   = FW - OUT_W;

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    localparam int IW = hb_pkg::stage_in_w(s);
    localparam int OW = IW + hb_pkg::CF + 1;
    logic                 v_in;
    logic signed [IW-1:0] d_in;
    logic                 v_out;
    logic signed [OW-1:0] d_out;
    if (s == 0) begin : g_first
      assign v_in = bit_valid;
      assign d_in = $signed({{(IW-1){~bit_in}}, 1'b1});   // 1 -> +1, 0 -> -1
    end else begin : g_next
      assign v_in = g_stg[s-1].v_out;
      assign d_in = g_stg[s-1].d_out;
    end
    hb_stage #(.STAGE(s), .IW(IW), .OW(OW)) u_stage (
      .clk(clk), .rst(rst), .in_valid(v_in), .in_data(d_in),
      .out_valid(v_out), .out_data(d_out)
    );
  end

  logic signed [FW-1:0] last_res;
  logic signed [FW:0]   rnd_full;
  logic                 rnd_fits;

  function automatic logic signed [FW:0] round_half_up(input logic signed [FW-1:0] v);
    logic signed [FW:0] t;
    t = (FW+1)'(v) + ((FW+1)'(1) <<< (SH - 1));
    return t >>> SH;
  endfunction

  assign last_res  = g_stg[NSTG-1].d_out;
  assign rnd_full  = round_half_up(last_res);
  assign rnd_fits  = (rnd_full[FW:OUT_W-1] == '0) || (rnd_full[FW:OUT_W-1] == '1);
  assign out_data  = rnd_full[OUT_W-1:0];
  assign out_valid = g_stg[NSTG-1].v_out;

  // R10: rounded result never needs more than OUT_W bits
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> rnd_fits);
  // R9: output word is cleared on the clock after reset
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_data == '0));
endmodule

// File: tb/tb_hb_decim_chain.sv
`timescale 1ns/1ps
module tb_hb_decim_chain;
  logic clk = 1'b0, rst = 1'b1, bit_valid = 1'b0, bit_in = 1'b0;
  logic               out_valid;
  logic signed [23:0] out_data;
  always #2.5 clk = ~clk;

  hb_decim_chain dut (.clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
                      .out_valid(out_valid), .out_data(out_data));

  int n_chk = 0, n_err = 0, n_out = 0;
  longint last_out = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model: history queues per stage, newest first
  int     tap_tb [5][11];
  int     len_tb [5];
  longint hist [5][$];
  bit     mph [5];
  bit     mv  [5];
  longint md  [5];

  initial begin
    tap_tb[0] = '{64, 128, 64, 0, 0, 0, 0, 0, 0, 0, 0};
    tap_tb[1] = '{-16, 0, 80, 128, 80, 0, -16, 0, 0, 0, 0};
    tap_tb[2] = tap_tb[1];
    tap_tb[3] = '{6, 0, -26, 0, 84, 128, 84, 0, -26, 0, 6};
    tap_tb[4] = tap_tb[3];
    len_tb    = '{3, 7, 7, 11, 11};
  end

  function automatic longint rnd24(input longint v);
    return (v + (64'sd1 <<< 22)) >>> 23;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 5; s++) begin
        hist[s].delete(); mph[s] = 0; mv[s] = 0; md[s] = 0;
      end
    end else begin
      for (int s = 4; s >= 0; s--) begin
        bit vin; longint din; longint acc;
        if (s == 0) begin vin = bit_valid; din = bit_in ? 1 : -1; end
        else begin vin = mv[s-1]; din = md[s-1]; end
        mv[s] = 0;
        if (vin) begin
          hist[s].push_front(din);
          if (hist[s].size() > len_tb[s]) void'(hist[s].pop_back());
          if (mph[s]) begin
            acc = 0;
            for (int k = 0; k < hist[s].size(); k++) acc += tap_tb[s][k] * hist[s][k];
            md[s] = acc;
            mv[s] = 1;
          end
          mph[s] = ~mph[s];
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // compare with the model on every clock, away from the edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(out_valid == mv[4], "R3 strobe", longint'(out_valid), longint'(mv[4]));
      check(longint'(out_data) == rnd24(md[4]), "R6 R8 R10 data", longint'(out_data), rnd24(md[4]));
      if (out_valid) begin n_out++; last_out = longint'(out_data); end
    end
  end

  task automatic send(input bit b, input bit v);
    @(negedge clk);
    bit_valid = v; bit_in = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; bit_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1;
    repeat (4) @(negedge clk);
    check(out_valid == 0, "R9 reset valid", longint'(out_valid), 0);
    check(out_data == 0, "R9 reset data", longint'(out_data), 0);
    rst = 0;

    // R1 R4: steady ones
    n_out = 0;
    for (int i = 0; i < 640; i++) send(1'b1, 1'b1);
    idle(8);
    check(last_out == 131072, "R4 R1 ones", last_out, 131072);
    check(n_out == 20, "R2 count ones", n_out, 20);

    // R1 R4: steady zeros
    do_reset(); n_out = 0;
    for (int i = 0; i < 640; i++) send(1'b0, 1'b1);
    idle(8);
    check(last_out == -131072, "R4 R1 zeros", last_out, -131072);
    check(n_out == 20, "R2 count zeros", n_out, 20);

    // R5: alternating
    do_reset(); n_out = 0;
    for (int i = 0; i < 640; i++) send(i[0] == 0, 1'b1);
    idle(8);
    check(last_out == 0, "R5 alternating", last_out, 0);
    check(n_out == 20, "R2 count alternating", n_out, 20);

    // R7: random bits with random idle gaps
    do_reset(); n_out = 0;
    for (int sent = 0; sent < 1280; ) begin
      step_lfsr();
      if (lfsr[3]) begin send(lfsr[0], 1'b1); sent++; end
      else send(lfsr[0], 1'b0);
    end
    idle(8);
    check(n_out == 40, "R7 count with gaps", n_out, 40);

    // R9: reset after an odd number of bits, then ones
    for (int i = 0; i < 45; i++) begin step_lfsr(); send(lfsr[1], 1'b1); end
    do_reset(); n_out = 0;
    for (int i = 0; i < 64; i++) send(1'b1, 1'b1);
    idle(8);
    check(n_out == 2, "R9 phase cleared", n_out, 2);
    check(last_out == rnd24(md[4]), "R9 history cleared", last_out, rnd24(md[4]));

    finish_run();
  end
endmodule